// File: doc/BRIEF.md
# GPIO Pad Community Register Block

This block is the register front end for a group of up to 32 general-purpose pads. Each pad is configured through a two-dword entry in a pad table. The table sits at a fixed byte offset that software discovers by reading a read-only pointer register. The configuration sets the output value, turns the output driver and the input receiver on or off, selects the pad mode, and chooses the termination. The block drives each pad's output value and output-enable, and it requests a pull-up or a pull-down. It passes each pad input through a synchronizer and shows it as a read-only bit of configuration dword 0.

A 2-bit owner field per pad decides whether host writes to that pad's table entry take effect. A nonzero pad mode disconnects the GPIO path from the pad. Per-pad event pulses from the event-detection logic set write-1-to-clear status bits. Status, enable and a per-pad routing bit form two outputs. One is a combined GPIO interrupt, which a routing bit sends to the primary or the secondary interrupt pin. The other is an event for the alternate (ACPI) path.

Software uses the block over a small command/response bus. A command is accepted when `cmd_valid` and `cmd_ready` are both high. A read returns one response on `rsp_valid`/`rsp_rdata`. That response holds still until `rsp_ready` is high. While an unaccepted response is pending, `cmd_ready` stays low, so back-pressure on the response side stalls the command side. Writes produce no response.

Top module: `gpio_pad_community`

## Requirements
- R1: Offset 0x00C reads back the byte offset of the pad table (parameter, default 0x400). Writes to it have no effect.
- R2: Pad p's dword 0 is at table + 8p and its dword 1 is at table + 8p + 4. The dword 0 fields are: bit 0 output value, bit 8 output disable, bit 9 input disable, bits 13:10 pad mode, bit 28 force-input-high. They read back as written. After reset dword 0 reads 0x100 when the pad input is low.
- R3: Dword 0 bit 1 is read-only and shows the synchronized pad input. It reads 1 whenever bit 28 is set. Otherwise it reads 0 whenever bit 9 is set.
- R4: `pad_oe[p]` is high only when bit 8 is clear and the mode is 0. `pad_out[p]` equals bit 0 when the mode is 0, and is 0 otherwise.
- R5: Dword 1 bits 13:10 select termination: 0xC gives `pad_pu`, 0x4 gives `pad_pd`, and any other value gives neither. Bits 9:8 and 17:14 are plain read/write storage.
- R6: The owner fields are 2 bits per pad, 16 pads per dword, starting at 0x020. The field for pad p is at bits 2(p mod 16)+1 : 2(p mod 16). Writes to a pad's table entry are ignored unless its owner field is 0.
- R7: A `pad_evt[p]` pulse sets status bit p (offset 0x100). Writing 1 to a status bit clears it. A set and a clear of the same bit in the same cycle leaves the bit set.
- R8: The combined interrupt is the OR over pads of status AND enable AND routing bit. It appears on `irq_gpio` when bit 3 of offset 0x010 is 0, and on `irq_alt` when that bit is 1. The two outputs are never both high.
- R9: `sci_evt` is the OR over pads of status AND enable AND NOT routing bit.
- R10: Reads of unmapped offsets return 0. This includes the dwords just past the last pad entry.
- R11: `cmd_ready` is high whenever no response is pending, or when the pending one is taken in this cycle. A pending response keeps `rsp_valid` and `rsp_rdata` stable until `rsp_ready`.
- R12: The routing bits (0x080, 1 = GPIO interrupt) and enable bits (0x110) are read/write, one bit per pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_addr | input | ADDR_W | Byte offset |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | NUM_PADS | Raw pad inputs |
| pad_out | output | NUM_PADS | Pad output values |
| pad_oe | output | NUM_PADS | Pad output enables |
| pad_pu | output | NUM_PADS | Pull-up requests |
| pad_pd | output | NUM_PADS | Pull-down requests |
| pad_evt | input | NUM_PADS | Per-pad event pulses |
| irq_gpio | output | 1 | Combined interrupt, primary route |
| irq_alt | output | 1 | Combined interrupt, secondary route |
| sci_evt | output | 1 | Events routed to the alternate path |

## Verification
The bench writes the table entry of a pad whose owner field is nonzero, then reads the entry back and checks the output-enable. A design that skipped the owner gate would return the written value and drive the pad. A status clear is written in the same cycle as a new event on the same bit. If the clear wins, that event is silently lost. The force-high and receiver-disable bits are exercised against a live pad input, which catches a wrong priority or a missing synchronizer path. Reads just past the last pad entry, and a response held by back-pressure, expose an off-by-one table bound and a response overwritten while stalled.

// File: rtl/gpio_pc_pkg.sv
package gpio_pc_pkg;

  localparam int OFS_TBLPTR = 'h00C;
  localparam int OFS_MISC   = 'h010;
  localparam int OFS_OWN    = 'h020;
  localparam int OFS_ROUTE  = 'h080;
  localparam int OFS_STS    = 'h100;
  localparam int OFS_EN     = 'h110;
  localparam int MISC_ROUTE_BIT = 3;
  localparam logic [3:0] TERM_PD = 4'h4;
  localparam logic [3:0] TERM_PU = 4'hC;

  typedef struct packed {
    logic       force_hi;
    logic [3:0] mode;
    logic       rx_off;
    logic       tx_off;
    logic       tx_val;
  } dw0_t;

  typedef struct packed {
    logic [3:0] stby_state;
    logic [3:0] term;
    logic [1:0] stby_term;
  } dw1_t;

  localparam dw0_t DW0_RST = '{force_hi: 1'b0, mode: 4'h0, rx_off: 1'b0,
                               tx_off: 1'b1, tx_val: 1'b0};
  localparam dw1_t DW1_RST = '0;

  function automatic logic [31:0] dw0_pack(dw0_t c, logic rx);
    logic [31:0] w;
    w = '0;
    w[0]     = c.tx_val;
    w[1]     = rx;
    w[8]     = c.tx_off;
    w[9]     = c.rx_off;
    w[13:10] = c.mode;
    w[28]    = c.force_hi;
    return w;
  endfunction

  function automatic dw0_t dw0_unpack(logic [31:0] w);
    dw0_t c;
    c.tx_val   = w[0];
    c.tx_off   = w[8];
    c.rx_off   = w[9];
    c.mode     = w[13:10];
    c.force_hi = w[28];
    return c;
  endfunction

  function automatic logic [31:0] dw1_pack(dw1_t c);
    logic [31:0] w;
    w = '0;
    w[9:8]   = c.stby_term;
    w[13:10] = c.term;
    w[17:14] = c.stby_state;
    return w;
  endfunction

  function automatic dw1_t dw1_unpack(logic [31:0] w);
    dw1_t c;
    c.stby_term  = w[9:8];
    c.term       = w[13:10];
    c.stby_state = w[17:14];
    return c;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PADS = 32,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] d,
  output logic [NUM_PADS-1:0] q
);
  logic [NUM_PADS-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pad_cfg.sv
module gpio_pad_cfg
  import gpio_pc_pkg::*;
#(
  parameter int NUM_PADS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] we0,
  input  logic [NUM_PADS-1:0] we1,
  input  logic [31:0]         wdata,
  output dw0_t                c0_q [NUM_PADS],
  output dw1_t                c1_q [NUM_PADS]
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c0_q[p] <= DW0_RST;
        c1_q[p] <= DW1_RST;
      end else begin
        if (we0[p]) c0_q[p] <= dw0_unpack(wdata);
        if (we1[p]) c1_q[p] <= dw1_unpack(wdata);
      end
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs #(
  parameter int NUM_PADS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] evt,
  input  logic                sts_w1c,
  input  logic                en_we,
  input  logic                route_we,
  input  logic [NUM_PADS-1:0] wdata,
  output logic [NUM_PADS-1:0] sts_q,
  output logic [NUM_PADS-1:0] en_q,
  output logic [NUM_PADS-1:0] route_q,
  output logic                gpio_any,
  output logic                acpi_any
);
  logic [NUM_PADS-1:0] clr;
  assign clr = sts_w1c ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q   <= '0;
      en_q    <= '0;
      route_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | evt;
      if (en_we)    en_q    <= wdata;
      if (route_we) route_q <= wdata;
    end
  end

  assign gpio_any = |(sts_q & en_q & route_q);
  assign acpi_any = |(sts_q & en_q & ~route_q);
endmodule

// File: rtl/gpio_pad_community.sv
module gpio_pad_community
  import gpio_pc_pkg::*;
#(
  parameter int NUM_PADS    = 32,
  parameter int ADDR_W      = 12,
  parameter int PAD_TBL_OFS = 'h400,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_write,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [31:0]         cmd_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [31:0]         rsp_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] pad_pu,
  output logic [NUM_PADS-1:0] pad_pd,
  input  logic [NUM_PADS-1:0] pad_evt,
  output logic                irq_gpio,
  output logic                irq_alt,
  output logic                sci_evt
);
  localparam int PAD_IW  = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam int TBL_END = PAD_TBL_OFS + NUM_PADS * 8;

  logic                accept, wr, rd;
  logic                in_tbl, dsel;
  logic [ADDR_W-1:0]   tbl_rel;
  logic [PAD_IW-1:0]   pad_idx;
  logic [NUM_PADS-1:0] we0, we1, rx_sync, rx_bit;
  logic [2*NUM_PADS-1:0] own_q;
  logic                route_sel_q;
  logic [NUM_PADS-1:0] sts_q, en_q, route_q;
  logic                gpio_any, acpi_any;
  logic [31:0]         rdata;
  dw0_t                c0_q [NUM_PADS];
  dw1_t                c1_q [NUM_PADS];

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign wr        = accept && cmd_write;
  assign rd        = accept && !cmd_write;

  assign in_tbl  = (int'(cmd_addr) >= PAD_TBL_OFS) && (int'(cmd_addr) < TBL_END);
  assign tbl_rel = cmd_addr - ADDR_W'(PAD_TBL_OFS);
  assign pad_idx = PAD_IW'(tbl_rel >> 3);
  assign dsel    = tbl_rel[2];

  // Owner-gated table write strobes
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_we
    logic hit;
    assign hit    = wr && in_tbl && (int'(pad_idx) == p) && (own_q[2*p +: 2] == 2'd0);
    assign we0[p] = hit && !dsel;
    assign we1[p] = hit && dsel;
  end

  // Ownership and routing-select storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q       <= '0;
      route_sel_q <= 1'b0;
    end else if (wr) begin
      for (int p = 0; p < NUM_PADS; p++) begin
        if (cmd_addr == ADDR_W'(OFS_OWN + 4 * (p / 16)))
          own_q[2*p +: 2] <= cmd_wdata[2*(p % 16) +: 2];
      end
      if (cmd_addr == ADDR_W'(OFS_MISC)) route_sel_q <= cmd_wdata[MISC_ROUTE_BIT];
    end
  end

  gpio_in_sync #(.NUM_PADS(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(rx_sync)
  );

  gpio_pad_cfg #(.NUM_PADS(NUM_PADS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we0(we0), .we1(we1), .wdata(cmd_wdata),
    .c0_q(c0_q), .c1_q(c1_q)
  );

  gpio_irq_regs #(.NUM_PADS(NUM_PADS)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(pad_evt),
    .sts_w1c(wr && cmd_addr == ADDR_W'(OFS_STS)),
    .en_we(wr && cmd_addr == ADDR_W'(OFS_EN)),
    .route_we(wr && cmd_addr == ADDR_W'(OFS_ROUTE)),
    .wdata(cmd_wdata[NUM_PADS-1:0]),
    .sts_q(sts_q), .en_q(en_q), .route_q(route_q),
    .gpio_any(gpio_any), .acpi_any(acpi_any)
  );

  // Pad-side drive
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic gpio_mode;
    assign gpio_mode  = (c0_q[p].mode == 4'h0);
    assign pad_oe[p]  = gpio_mode && !c0_q[p].tx_off;
    assign pad_out[p] = gpio_mode && c0_q[p].tx_val;
    assign pad_pu[p]  = (c1_q[p].term == TERM_PU);
    assign pad_pd[p]  = (c1_q[p].term == TERM_PD);
    assign rx_bit[p]  = c0_q[p].force_hi || (!c0_q[p].rx_off && rx_sync[p]);
  end

  assign irq_gpio = gpio_any && !route_sel_q;
  assign irq_alt  = gpio_any && route_sel_q;
  assign sci_evt  = acpi_any;

  // Read mux
  always_comb begin
    rdata = '0;
    if (in_tbl) begin
      rdata = dsel ? dw1_pack(c1_q[pad_idx]) : dw0_pack(c0_q[pad_idx], rx_bit[pad_idx]);
    end else if (cmd_addr == ADDR_W'(OFS_TBLPTR)) begin
      rdata = 32'(PAD_TBL_OFS);
    end else if (cmd_addr == ADDR_W'(OFS_MISC)) begin
      rdata[MISC_ROUTE_BIT] = route_sel_q;
    end else if (cmd_addr == ADDR_W'(OFS_ROUTE)) begin
      rdata[NUM_PADS-1:0] = route_q;
    end else if (cmd_addr == ADDR_W'(OFS_STS)) begin
      rdata[NUM_PADS-1:0] = sts_q;
    end else if (cmd_addr == ADDR_W'(OFS_EN)) begin
      rdata[NUM_PADS-1:0] = en_q;
    end else begin
      for (int p = 0; p < NUM_PADS; p++) begin
        if (cmd_addr == ADDR_W'(OFS_OWN + 4 * (p / 16)))
          rdata[2*(p % 16) +: 2] = own_q[2*p +: 2];
      end
    end
  end

  // One-entry response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rdata;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_pad_community_chk.sv
module gpio_pad_community_chk #(
  parameter int NUM_PADS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_ready,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [31:0]         rsp_rdata,
  input logic [NUM_PADS-1:0] pad_evt,
  input logic [NUM_PADS-1:0] sts_q,
  input logic [NUM_PADS-1:0] pad_pu,
  input logic [NUM_PADS-1:0] pad_pd,
  input logic                irq_gpio,
  input logic                irq_alt
);
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R11
  cmd_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> cmd_ready);

  // R5
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  // R8
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_gpio && irq_alt));

  // R7
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pad_evt) |=> ((sts_q & $past(pad_evt)) == $past(pad_evt)));
endmodule

bind gpio_pad_community gpio_pad_community_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .pad_evt(pad_evt),
  .sts_q(sts_q), .pad_pu(pad_pu), .pad_pd(pad_pd),
  .irq_gpio(irq_gpio), .irq_alt(irq_alt)
);

// File: tb/sim_gpio_pad_community.sv
`timescale 1ns/1ps
module sim_gpio_pad_community;
  localparam int N = 32;
  localparam int TB = 'h400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic [N-1:0] pad_in = '0, pad_evt = '0;
  logic cmd_ready, rsp_valid, irq_gpio, irq_alt, sci_evt;
  logic [31:0] rsp_rdata;
  logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  gpio_pad_community u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_evt(pad_evt), .irq_gpio(irq_gpio),
    .irq_alt(irq_alt), .sci_evt(sci_evt)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops scoreboard on each accepted response
  always @(negedge clk) begin
    #1;
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected response", rsp_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  // Driver tasks: called at a falling edge, return at a falling edge
  task automatic bus_wr(input int a, input logic [31:0] d);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 12'(a); cmd_wdata = d;
    @(posedge clk); #1 cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input int a, input logic [31:0] e, input string tag);
    while (!cmd_ready) @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 12'(a);
    @(posedge clk); #1 cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [N-1:0] m);
    pad_evt = m;
    @(posedge clk); #1 pad_evt = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(pad_oe == '0, "R4 reset oe", pad_oe, 32'h0);
    chk(!irq_gpio && !irq_alt && !sci_evt, "R8 reset irq", {irq_gpio, irq_alt, sci_evt}, 32'h0);
    bus_rd(TB, 32'h100, "R2 reset dw0");
    // R1 pointer, write ignored
    bus_rd('h00C, TB, "R1 table pointer");
    bus_wr('h00C, 32'hFFFF);
    bus_rd('h00C, TB, "R1 pointer after write");
    // R4 drive
    bus_wr(TB + 3*8, 32'h1);
    chk(pad_oe[3] && pad_out[3], "R4 gpio drive", {pad_oe[3], pad_out[3]}, 32'h3);
    bus_rd(TB + 3*8, 32'h1, "R2 dw0 readback");
    bus_wr(TB + 3*8, 32'h401);
    chk(!pad_oe[3] && !pad_out[3], "R4 native mode off", {pad_oe[3], pad_out[3]}, 32'h0);
    bus_rd(TB + 3*8, 32'h401, "R2 mode readback");
    // R3 input path
    pad_in[5] = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(TB + 5*8, 32'h102, "R3 rx sampled");
    bus_wr(TB + 5*8, 32'h300);
    bus_rd(TB + 5*8, 32'h300, "R3 rx disabled");
    bus_wr(TB + 6*8, 32'h1000_0100);
    bus_rd(TB + 6*8, 32'h1000_0102, "R3 forced high");
    // R5 termination
    bus_wr(TB + 7*8 + 4, 32'h3000);
    chk(pad_pu[7] && !pad_pd[7], "R5 pull-up", {pad_pu[7], pad_pd[7]}, 32'h2);
    bus_wr(TB + 7*8 + 4, 32'h1000);
    chk(!pad_pu[7] && pad_pd[7], "R5 pull-down", {pad_pu[7], pad_pd[7]}, 32'h1);
    bus_wr(TB + 7*8 + 4, 32'h3C300);
    chk(!pad_pu[7] && !pad_pd[7], "R5 no pull", {pad_pu[7], pad_pd[7]}, 32'h0);
    bus_rd(TB + 7*8 + 4, 32'h3C300, "R5 dw1 readback");
    // R6 ownership
    bus_wr('h020, 32'h0001_0000);
    bus_rd('h020, 32'h0001_0000, "R6 owner word0");
    bus_wr(TB + 8*8, 32'h1);
    chk(!pad_oe[8], "R6 foreign pad not driven", pad_oe[8], 32'h0);
    bus_rd(TB + 8*8, 32'h100, "R6 foreign write ignored");
    bus_wr('h024, 32'h300);
    bus_rd('h024, 32'h300, "R6 owner word1");
    // R12 / R7 / R8 / R9
    bus_wr('h080, 32'h1);
    bus_wr('h110, 32'h3);
    bus_rd('h080, 32'h1, "R12 route readback");
    bus_rd('h110, 32'h3, "R12 enable readback");
    pulse_evt(32'h1);
    chk(irq_gpio && !irq_alt, "R8 primary route", {irq_gpio, irq_alt}, 32'h2);
    bus_rd('h100, 32'h1, "R7 status set");
    bus_wr('h010, 32'h8);
    chk(!irq_gpio && irq_alt, "R8 secondary route", {irq_gpio, irq_alt}, 32'h1);
    bus_rd('h010, 32'h8, "R8 misc readback");
    bus_wr('h010, 32'h0);
    pulse_evt(32'h2);
    chk(sci_evt, "R9 alternate event", sci_evt, 32'h1);
    bus_wr('h100, 32'h1);
    chk(!irq_gpio && sci_evt, "R7 w1c", {irq_gpio, sci_evt}, 32'h1);
    bus_rd('h100, 32'h2, "R7 status after clear");
    pad_evt = 32'h1;
    bus_wr('h100, 32'h1);
    pad_evt = '0;
    bus_rd('h100, 32'h3, "R7 set wins over clear");
    bus_wr('h100, 32'h3);
    chk(!irq_gpio && !sci_evt, "R9 all cleared", {irq_gpio, sci_evt}, 32'h0);
    // R10 unmapped
    bus_rd('h300, 32'h0, "R10 hole");
    bus_rd(TB + N*8, 32'h0, "R10 past table");
    bus_rd('h014, 32'h0, "R10 gap");
    // R11 back-pressure
    repeat (2) @(negedge clk);
    rsp_ready = 1'b0;
    bus_rd('h00C, TB, "R11 held response");
    for (int i = 0; i < 3; i++) begin
      chk(!cmd_ready, "R11 stall", cmd_ready, 32'h0);
      chk(rsp_valid && rsp_rdata == TB, "R11 stable data", rsp_rdata, TB);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all responses seen", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule